// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block is the host-side engine that turns one high-level flash request into the exact series of bus cycles an 8-bit multiplexed NAND device expects. A request carries an operation code, a 12-bit column, a 17-bit row and, for operations that move data, a byte count. It is accepted through a valid/ready handshake. The sequencer then walks the device through the command bytes, the address bytes, any data bytes, the busy period and the final status read. Command, address and data all share a single 8-bit output bus, and two latch qualifiers tell them apart.

Every write strobe and read strobe is built from three programmable phase lengths: setup, low and hold. The same pulse engine serves command, address, write-data, status and read-data cycles. Write data is taken from a byte stream with valid/ready. Read data leaves on a byte stream with a one-cycle valid pulse. When the operation ends, a single-cycle done pulse presents the captured status byte and its pass/fail bit. A request the block cannot serve raises a reject pulse and leaves the flash bus untouched.

Top module: `nand_seq`

## Requirements
- R1: `req_ready` is high exactly when the sequencer is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. Operation codes: 0 page read, 1 page program, 2 block erase, 3 reset, 4 status read, 5 ID read.
- R2: Each bus byte is presented while chip enable is low and is latched by the device on the rising edge of the write strobe. A command byte has the command latch high and the address latch low. An address byte has the address latch high and the command latch low. A data byte has neither latch high. The two latches are never high together.
- R3: Page read and page program send five address bytes in this order: column[7:0], {4'b0, column[11:8]}, row[7:0], row[15:8], {7'b0, row[16]}.
- R4: Block erase sends exactly three address bytes, row[7:0], row[15:8] and {7'b0, row[16]}, and sends no column byte.
- R5: Command bytes are: read 00h, address, 30h. Program 80h, address, data, 10h. Erase 60h, row address, D0h. Reset FFh. Status 70h. ID read 90h followed by one 00h address byte.
- R6: After the confirm byte of a read, program or erase, the sequencer waits for ready/busy to go low and then high again. It then issues 70h and captures one status byte. `done_status` carries that byte and `done_fail` equals its bit 0. A read then issues 00h again before the data is read out.
- R7: No command byte other than FFh or 70h is issued while ready/busy is low. Read, program, erase and ID read wait for the device to be ready before their first command. Reset and status read start at once.
- R8: Each write or read strobe stays low for max(`cfg_low`,1) clock cycles. It is preceded by max(`cfg_setup`,1) and followed by max(`cfg_hold`,1) cycles with the strobe high. The two strobes are never low together.
- R9: Read and ID read sample the I/O bus on the rising edge of the read strobe. Exactly `req_len` bytes are delivered, in order, as one-cycle `rd_valid` pulses.
- R10: Program takes exactly `req_len` bytes from the write stream and drives them on the bus in arrival order. The sequencer waits while `wr_valid` is low.
- R11: An operation code of 6 or 7, or a data-moving operation with `req_len` equal to 0 or greater than the page size (2112), gives a one-cycle `reject` pulse. Such a request drives no bus cycle and the sequencer stays ready. A length of exactly 2112 is accepted.
- R12: `done` is a single-cycle pulse. Reset and ID read report `done_status` = 0 and `done_fail` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_op | input | 3 | Operation code |
| req_col | input | 12 | Column address |
| req_row | input | 17 | Row (page) address |
| req_len | input | 12 | Data byte count for read, program and ID read |
| cfg_setup | input | 4 | Strobe setup cycles |
| cfg_low | input | 4 | Strobe low cycles |
| cfg_hold | input | 4 | Strobe hold cycles |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte valid pulse |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Operation complete pulse |
| done_status | output | 8 | Captured status byte |
| done_fail | output | 1 | Status bit 0 |
| reject | output | 1 | Unsupported request pulse |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch qualifier |
| nand_ale | output | 1 | Address latch qualifier |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte driven to the I/O bus |
| nand_dq_oe | output | 1 | I/O bus output enable |
| nand_dq_in | input | 8 | Byte from the I/O bus |
| nand_rb_n | input | 1 | Ready/busy, low while busy |

## Verification
The hardest case to reach is a request that arrives while the device already reports busy. A device model only goes busy after a confirm byte, and the sequencer then waits out that busy period itself. To reach the case, the bench holds ready/busy low from outside. It first issues a status read, which has to finish during that busy period. It then issues an erase and checks that no bus cycle appears while the line stays low, and that the full erase sequence follows once the line is released. Random operations with random strobe timings, including zero-valued settings, cover the remaining orderings. The column and page extremes and the length limits are covered by directed requests.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int COL_W = 12;
  localparam int ROW_W = 17;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_PROG   = 3'd1,
    OP_ERASE  = 3'd2,
    OP_RESET  = 3'd3,
    OP_STATUS = 3'd4,
    OP_READID = 3'd5
  } op_e;

  function automatic logic op_known(input logic [2:0] code);
    return code <= 3'd5;
  endfunction

  function automatic logic op_moves_data(input op_e o);
    return (o == OP_READ) || (o == OP_PROG) || (o == OP_READID);
  endfunction

  function automatic logic [7:0] first_cmd(input op_e o);
    case (o)
      OP_READ:   return 8'h00;
      OP_PROG:   return 8'h80;
      OP_ERASE:  return 8'h60;
      OP_RESET:  return 8'hFF;
      OP_STATUS: return 8'h70;
      default:   return 8'h90;
    endcase
  endfunction

  function automatic logic [7:0] confirm_cmd(input op_e o);
    case (o)
      OP_READ:  return 8'h30;
      OP_PROG:  return 8'h10;
      OP_ERASE: return 8'hD0;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic [2:0] addr_cycles(input op_e o);
    case (o)
      OP_READ, OP_PROG: return 3'd5;
      OP_ERASE:         return 3'd3;
      default:          return 3'd1;
    endcase
  endfunction

  // byte slot k: 0,1 column; 2,3,4 row. Erase starts at slot 2.
  function automatic logic [7:0] addr_byte(input op_e o, input logic [COL_W-1:0] c,
                                           input logic [ROW_W-1:0] r, input logic [2:0] i);
    logic [2:0] k;
    if (o == OP_READID) return 8'h00;
    k = (o == OP_ERASE) ? i + 3'd2 : i;
    case (k)
      3'd0:    return c[7:0];
      3'd1:    return {4'h0, c[11:8]};
      3'd2:    return r[7:0];
      3'd3:    return r[15:8];
      default: return {7'h0, r[16]};
    endcase
  endfunction
endpackage

// File: rtl/nand_seq_pulse.sv
module nand_seq_pulse #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] t_setup,
  input  logic [TW-1:0] t_low,
  input  logic [TW-1:0] t_hold,
  output logic          active,
  output logic          strobe_lo,
  output logic          rise,
  output logic          fin
);
  typedef enum logic [1:0] {PH_IDLE, PH_SET, PH_LOW, PH_HOLD} ph_e;

  ph_e           ph;
  logic [TW-1:0] cnt;
  logic [TW-1:0] lim;
  logic          last;

  function automatic logic [TW-1:0] at_least_one(input logic [TW-1:0] v);
    return (v == '0) ? TW'(1) : v;
  endfunction

  always_comb begin
    case (ph)
      PH_SET:  lim = at_least_one(t_setup);
      PH_LOW:  lim = at_least_one(t_low);
      default: lim = at_least_one(t_hold);
    endcase
  end

  assign last      = (cnt == lim);
  assign active    = (ph != PH_IDLE);
  assign strobe_lo = (ph == PH_LOW);
  assign rise      = strobe_lo && last;
  assign fin       = (ph == PH_HOLD) && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin ph <= PH_SET; cnt <= TW'(1); end
        PH_SET:  if (last) begin ph <= PH_LOW;  cnt <= TW'(1); end else cnt <= cnt + 1'b1;
        PH_LOW:  if (last) begin ph <= PH_HOLD; cnt <= TW'(1); end else cnt <= cnt + 1'b1;
        default: if (last) begin ph <= PH_IDLE; cnt <= '0;     end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  // R8
  pulse_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);
  // R8
  pulse_rise_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !strobe_lo);
endmodule

// File: rtl/nand_seq_addr.sv
module nand_seq_addr
  import nand_seq_pkg::*;
(
  input  op_e              op,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  input  logic [2:0]       idx,
  output logic [7:0]       abyte,
  output logic [2:0]       acount
);
  assign abyte  = addr_byte(op, col, row, idx);
  assign acount = addr_cycles(op);
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 2112,
  parameter int TW         = 4,
  localparam int LEN_W     = $clog2(PAGE_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [COL_W-1:0] req_col,
  input  logic [ROW_W-1:0] req_row,
  input  logic [LEN_W-1:0] req_len,
  input  logic [TW-1:0]    cfg_setup,
  input  logic [TW-1:0]    cfg_low,
  input  logic [TW-1:0]    cfg_hold,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic [7:0]       done_status,
  output logic             done_fail,
  output logic             reject,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_dq_out,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_in,
  input  logic             nand_rb_n
);
  typedef enum logic [3:0] {
    S_IDLE, S_WAITRDY, S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_WFALL,
    S_WRISE, S_STCMD, S_STRD, S_RDCMD, S_RDATA, S_DONE
  } st_e;

  st_e              state;
  op_e              op_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [LEN_W-1:0] len_q;
  logic [2:0]       idx;
  logic [LEN_W-1:0] bcnt;
  logic             issued;
  logic [7:0]       status_q;
  logic [7:0]       wbuf;
  logic             rb_s1, rb_s2;

  // named internal events
  logic req_ok, take_good, take_bad;
  logic bus_st, rd_st, cle_st, eng_start;
  logic eng_active, eng_lo, eng_rise, eng_fin;
  logic [7:0] abyte, bus_byte;
  logic [2:0] acount;
  logic last_addr, last_byte;

  assign req_ok = op_known(req_op) &&
                  (!op_moves_data(op_e'(req_op)) ||
                   (req_len != '0 && req_len <= LEN_W'(PAGE_BYTES)));
  assign take_good = req_valid && (state == S_IDLE) && req_ok;
  assign take_bad  = req_valid && (state == S_IDLE) && !req_ok;

  assign cle_st = (state == S_CMD1) || (state == S_CMD2) ||
                  (state == S_STCMD) || (state == S_RDCMD);
  assign rd_st  = (state == S_STRD) || (state == S_RDATA);
  assign bus_st = cle_st || rd_st || (state == S_ADDR) || (state == S_WDATA);
  assign eng_start = bus_st && !issued && !(state == S_WDATA && !wr_valid);
  assign wr_ready  = (state == S_WDATA) && eng_start;
  assign last_addr = (idx == acount - 3'd1);
  assign last_byte = (bcnt == len_q - 1'b1);

  nand_seq_addr u_addr (
    .op(op_q), .col(col_q), .row(row_q), .idx(idx), .abyte(abyte), .acount(acount)
  );

  nand_seq_pulse #(.TW(TW)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(eng_start),
    .t_setup(cfg_setup), .t_low(cfg_low), .t_hold(cfg_hold),
    .active(eng_active), .strobe_lo(eng_lo), .rise(eng_rise), .fin(eng_fin)
  );

  always_comb begin
    case (state)
      S_CMD1:  bus_byte = first_cmd(op_q);
      S_CMD2:  bus_byte = confirm_cmd(op_q);
      S_STCMD: bus_byte = 8'h70;
      S_ADDR:  bus_byte = abyte;
      S_WDATA: bus_byte = wbuf;
      default: bus_byte = 8'h00;
    endcase
  end

  assign req_ready   = (state == S_IDLE);
  assign nand_ce_n   = (state == S_IDLE) || (state == S_DONE);
  assign nand_cle    = cle_st;
  assign nand_ale    = (state == S_ADDR);
  assign nand_we_n   = !(eng_lo && !rd_st);
  assign nand_re_n   = !(eng_lo && rd_st);
  assign nand_dq_out = bus_byte;
  assign nand_dq_oe  = bus_st && !rd_st;
  assign done        = (state == S_DONE);
  assign done_status = status_q;
  assign done_fail   = status_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;   op_q <= OP_READ;
      col_q <= '0;       row_q <= '0;       len_q <= '0;
      idx <= '0;         bcnt <= '0;        issued <= 1'b0;
      status_q <= '0;    wbuf <= '0;
      rd_data <= '0;     rd_valid <= 1'b0;  reject <= 1'b0;
      rb_s1 <= 1'b1;     rb_s2 <= 1'b1;
    end else begin
      rb_s1    <= nand_rb_n;
      rb_s2    <= rb_s1;
      rd_valid <= 1'b0;
      reject   <= take_bad;
      if (eng_start) issued <= 1'b1;
      else if (eng_fin) issued <= 1'b0;
      if (wr_ready) wbuf <= wr_data;
      if (eng_rise && state == S_STRD) status_q <= nand_dq_in;
      if (eng_rise && state == S_RDATA) begin
        rd_data  <= nand_dq_in;
        rd_valid <= 1'b1;
      end
      case (state)
        S_IDLE: if (take_good) begin
          op_q <= op_e'(req_op); col_q <= req_col; row_q <= req_row; len_q <= req_len;
          idx <= '0; bcnt <= '0; status_q <= '0;
          state <= (op_e'(req_op) == OP_RESET || op_e'(req_op) == OP_STATUS) ? S_CMD1 : S_WAITRDY;
        end
        S_WAITRDY: if (rb_s2) state <= S_CMD1;
        S_CMD1: if (eng_fin) begin
          case (op_q)
            OP_RESET:  state <= S_WFALL;
            OP_STATUS: state <= S_STRD;
            default:   state <= S_ADDR;
          endcase
        end
        S_ADDR: if (eng_fin) begin
          if (!last_addr)              idx <= idx + 3'd1;
          else if (op_q == OP_PROG)    state <= S_WDATA;
          else if (op_q == OP_READID)  state <= S_RDATA;
          else                         state <= S_CMD2;
        end
        S_WDATA: if (eng_fin) begin
          if (last_byte) state <= S_CMD2;
          else bcnt <= bcnt + 1'b1;
        end
        S_CMD2:  if (eng_fin) state <= S_WFALL;
        S_WFALL: if (!rb_s2) state <= S_WRISE;
        S_WRISE: if (rb_s2) state <= (op_q == OP_RESET) ? S_DONE : S_STCMD;
        S_STCMD: if (eng_fin) state <= S_STRD;
        S_STRD:  if (eng_fin) state <= (op_q == OP_READ) ? S_RDCMD : S_DONE;
        S_RDCMD: if (eng_fin) state <= S_RDATA;
        S_RDATA: if (eng_fin) begin
          if (last_byte) state <= S_DONE;
          else bcnt <= bcnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> nand_ce_n);
  // R2
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  // R2
  strobe_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  // R7
  busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && nand_cle && !rb_s2) |-> (nand_dq_out == 8'hFF || nand_dq_out == 8'h70));
  // R11
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> (nand_ce_n && req_ready));
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/nand_seq_bench.sv
module nand_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [11:0] req_col = '0;
  logic [16:0] req_row = '0;
  logic [11:0] req_len = '0;
  logic [3:0]  cfg_setup = 4'd1, cfg_low = 4'd1, cfg_hold = 4'd1;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_data;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        done, done_fail, reject;
  logic [7:0]  done_status;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out;
  logic [7:0]  nand_dq_in = '0;
  logic        nand_rb_n;

  always #5 clk = ~clk;

  nand_seq u_nand_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_col(req_col), .req_row(req_row), .req_len(req_len),
    .cfg_setup(cfg_setup), .cfg_low(cfg_low), .cfg_hold(cfg_hold),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .done_status(done_status),
    .done_fail(done_fail), .reject(reject), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in),
    .nand_rb_n(nand_rb_n)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic       dev_busy = 1'b0;
  logic       ext_busy = 1'b0;
  assign nand_rb_n = !(dev_busy || ext_busy);
  logic [7:0] mode = 8'h00;
  logic [7:0] abuf [0:4];
  int         a_cnt = 0;
  int         midx = 0;
  logic [7:0] stat_val = 8'h00;
  int         busy_viol = 0;
  logic [1:0] log_kind [0:63];
  logic [7:0] log_byte [0:63];
  int         log_n = 0;

  function automatic logic [7:0] id_byte(input int k);
    return 8'hA5 ^ 8'(k * 37);
  endfunction

  function automatic logic [7:0] exp_data(input int c, input int r, input int k);
    logic [11:0] s;
    logic [16:0] rr;
    s  = 12'(c) + 12'(k);
    rr = 17'(r);
    return s[7:0] ^ rr[7:0] ^ {rr[16], rr[14:8]};
  endfunction

  always @(posedge nand_we_n or negedge nand_re_n) begin
    if (!nand_re_n) begin
      logic [11:0] cs;
      cs = {abuf[1][3:0], abuf[0]} + 12'(midx);
      if (mode == 8'h70)      nand_dq_in = stat_val;
      else if (mode == 8'h90) nand_dq_in = id_byte(midx);
      else                    nand_dq_in = cs[7:0] ^ abuf[2] ^ {abuf[4][0], abuf[3][6:0]};
      midx++;
    end else if (!nand_ce_n) begin
      if (log_n < 64) begin
        log_kind[log_n] = nand_cle ? 2'd1 : (nand_ale ? 2'd2 : 2'd0);
        log_byte[log_n] = nand_dq_out;
        log_n++;
      end
      if (nand_cle) begin
        if (!nand_rb_n && nand_dq_out != 8'hFF && nand_dq_out != 8'h70) busy_viol++;
        mode  = nand_dq_out;
        a_cnt = 0;
        if (nand_dq_out == 8'h00 || nand_dq_out == 8'h90) midx = 0;
        if (nand_dq_out == 8'h30 || nand_dq_out == 8'h10 ||
            nand_dq_out == 8'hD0 || nand_dq_out == 8'hFF) begin
          fork
            begin
              repeat (2) @(posedge clk);
              dev_busy = 1'b1;
              repeat (4 + $urandom % 10) @(posedge clk);
              dev_busy = 1'b0;
            end
          join_none
        end
      end else if (nand_ale) begin
        if (a_cnt < 5) abuf[a_cnt] = nand_dq_out;
        a_cnt++;
      end
    end
  end

  // ---------------- write stream ----------------
  logic [7:0] wbytes [0:7];
  int         wr_idx = 0;
  bit         wr_en = 0;
  assign wr_data = wbytes[wr_idx[2:0]];
  always @(negedge clk) wr_valid <= wr_en && ($urandom % 4 != 0);
  always @(posedge clk) if (wr_valid && wr_ready) wr_idx <= wr_idx + 1;

  // ---------------- read stream ----------------
  int cur_op = 0, cur_col = 0, cur_row = 0;
  int rd_n = 0, rd_bad = 0;
  always @(posedge clk) begin
    if (rd_valid) begin
      logic [7:0] e;
      e = (cur_op == 5) ? id_byte(rd_n) : exp_data(cur_col, cur_row, rd_n);
      if (rd_data !== e) rd_bad++;
      rd_n++;
    end
  end

  // ---------------- strobe width monitor ----------------
  int  wl = 0, rl = 0, width_err = 0;
  logic we_p = 1'b1, re_p = 1'b1;
  always @(posedge clk) begin
    int want;
    want = (cfg_low == 0) ? 1 : int'(cfg_low);
    if (!nand_we_n) wl++;
    if (!nand_re_n) rl++;
    if (nand_we_n && !we_p) begin if (wl != want) width_err++; wl = 0; end
    if (nand_re_n && !re_p) begin if (rl != want) width_err++; rl = 0; end
    we_p = nand_we_n;
    re_p = nand_re_n;
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- expected sequence ----------------
  logic [1:0] ek [0:63];
  logic [7:0] eb [0:63];
  int         en;

  task automatic put(input logic [1:0] k, input logic [7:0] b);
    ek[en] = k; eb[en] = b; en++;
  endtask

  task automatic build_exp(input int op, input int col, input int row, input int len);
    logic [16:0] r;
    logic [11:0] c;
    r = 17'(row); c = 12'(col); en = 0;
    case (op)
      0: begin
        put(1, 8'h00); put(2, c[7:0]); put(2, {4'h0, c[11:8]});
        put(2, r[7:0]); put(2, r[15:8]); put(2, {7'h0, r[16]});
        put(1, 8'h30); put(1, 8'h70); put(1, 8'h00);
      end
      1: begin
        put(1, 8'h80); put(2, c[7:0]); put(2, {4'h0, c[11:8]});
        put(2, r[7:0]); put(2, r[15:8]); put(2, {7'h0, r[16]});
        for (int i = 0; i < len; i++) put(0, wbytes[i]);
        put(1, 8'h10); put(1, 8'h70);
      end
      2: begin
        put(1, 8'h60); put(2, r[7:0]); put(2, r[15:8]); put(2, {7'h0, r[16]});
        put(1, 8'hD0); put(1, 8'h70);
      end
      3: put(1, 8'hFF);
      4: put(1, 8'h70);
      default: begin put(1, 8'h90); put(2, 8'h00); end
    endcase
  endtask

  task automatic prep(input int op, input int col, input int row);
    log_n = 0; rd_n = 0; rd_bad = 0; wr_idx = 0;
    width_err = 0; busy_viol = 0;
    cur_op = op; cur_col = col; cur_row = row;
    stat_val = 8'($urandom);
    for (int i = 0; i < 8; i++) wbytes[i] = 8'($urandom);
    wr_en = (op == 1);
  endtask

  task automatic send(input int op, input int col, input int row, input int len);
    @(negedge clk);
    req_op = 3'(op); req_col = 12'(col); req_row = 17'(row); req_len = 12'(len);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_op(input int op, input int col, input int row, input int len);
    int   guard;
    string seq_tag;
    guard = 0;
    while (!done && guard < 40000) begin @(negedge clk); guard++; end
    chk(done, "R6 op completes", done, 1);
    if (op == 3 || op == 5) begin
      chk(done_status == 8'h00 && !done_fail, "R12 status zero", done_status, 0);
    end else begin
      chk(done_status == stat_val, "R6 status byte", done_status, stat_val);
      chk(done_fail == stat_val[0], "R6 fail bit", done_fail, stat_val[0]);
    end
    if (op <= 2) chk(!dev_busy, "R6 done after busy", dev_busy, 0);
    @(negedge clk);
    chk(!done, "R12 done single cycle", done, 0);
    build_exp(op, col, row, len);
    seq_tag = (op == 2) ? "R4 sequence" : ((op <= 1) ? "R3 sequence" : "R5 sequence");
    chk(log_n == en, seq_tag, log_n, en);
    for (int i = 0; i < en && i < log_n; i++) begin
      chk(log_kind[i] == ek[i], "R2 latch kind", log_kind[i], ek[i]);
      if (ek[i] == 2'd0) chk(log_byte[i] == eb[i], "R10 write byte", log_byte[i], eb[i]);
      else chk(log_byte[i] == eb[i], seq_tag, log_byte[i], eb[i]);
    end
    if (op == 1) chk(wr_idx == len, "R10 bytes consumed", wr_idx, len);
    if (op == 0 || op == 5) begin
      chk(rd_n == len, "R9 read count", rd_n, len);
      chk(rd_bad == 0, "R9 read data", rd_bad, 0);
    end else chk(rd_n == 0, "R9 no read data", rd_n, 0);
    chk(width_err == 0, "R8 strobe low width", width_err, 0);
    chk(busy_viol == 0, "R7 command while busy", busy_viol, 0);
    chk(req_ready, "R1 ready after done", req_ready, 1);
    wr_en = 0;
  endtask

  task automatic run_op(input int op, input int col, input int row, input int len);
    prep(op, col, row);
    send(op, col, row, len);
    chk(!req_ready, "R1 busy after accept", req_ready, 0);
    finish_op(op, col, row, len);
  endtask

  task automatic try_bad(input int op, input int len);
    prep(op, 0, 0);
    send(op, 5, 9, len);
    chk(reject, "R11 reject pulse", reject, 1);
    chk(req_ready && nand_ce_n, "R11 stays idle", {req_ready, nand_ce_n}, 3);
    repeat (6) @(negedge clk);
    chk(log_n == 0 && nand_ce_n, "R11 no bus cycle", log_n, 0);
    chk(!reject, "R11 reject single", reject, 0);
  endtask

  initial begin
    void'($urandom(32'd2451));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 reset ready", req_ready, 1);
    chk(nand_ce_n && nand_we_n && nand_re_n, "R2 reset bus idle",
        {nand_ce_n, nand_we_n, nand_re_n}, 7);
    chk(!done && !reject && !rd_valid, "R12 reset outputs quiet", done, 0);

    // directed corners
    cfg_setup = 1; cfg_low = 1; cfg_hold = 1;
    run_op(0, 0, 0, 4);
    cfg_setup = 0; cfg_low = 0; cfg_hold = 0;
    run_op(1, 2111, 131071, 8);
    cfg_setup = 2; cfg_low = 3; cfg_hold = 2;
    run_op(2, 12'hABC, 131071, 0);
    run_op(3, 0, 0, 0);
    run_op(4, 0, 0, 0);
    cfg_low = 5;
    run_op(5, 0, 0, 5);
    try_bad(6, 3);
    try_bad(7, 3);
    try_bad(0, 0);
    try_bad(0, 2113);
    try_bad(1, 0);
    cfg_setup = 1; cfg_low = 1; cfg_hold = 1;
    run_op(0, 100, 70000, 2112);

    // device already busy: status runs, erase waits
    ext_busy = 1'b1;
    repeat (4) @(negedge clk);
    run_op(4, 0, 0, 0);
    prep(2, 0, 65537);
    send(2, 0, 65537, 0);
    repeat (30) @(negedge clk);
    chk(log_n == 0 && !done, "R7 erase held while busy", log_n, 0);
    ext_busy = 1'b0;
    finish_op(2, 0, 65537, 0);

    // constrained random
    for (int n = 0; n < 30; n++) begin
      int op, col, row, len;
      op  = $urandom % 6;
      col = (n % 7 == 0) ? 2111 : int'($urandom % 2112);
      row = (n % 5 == 0) ? 131071 : int'($urandom % 131072);
      len = 1 + $urandom % 8;
      cfg_setup = 4'($urandom % 5);
      cfg_low   = 4'($urandom % 5);
      cfg_hold  = 4'($urandom % 5);
      run_op(op, col, row, len);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule